// File: doc/BRIEF.md
# Trace Fill Unit

The trace fill unit sits after instruction retirement and packs the dynamic instruction stream into trace-cache lines. Each cycle it may take one retired instruction: its word, its PC, a three-bit class code, the resolved direction of a conditional branch and the branch target. Instructions are collected into a line buffer until a stop condition is reached. The completed line then leaves as a single write that carries the tag and set index taken from the first instruction's PC, the packed instruction slots, the embedded-branch mask and direction flags, an ends-in-branch flag, and the two next-fetch addresses.

A trace stops at the sixteenth instruction. It also stops at the conditional branch that closes its third basic block, and at any control transfer with more than one possible successor: an indirect jump, a return or a system call. A flush input drops a partly built line.

Both stream edges use valid/ready. An instruction moves when `in_valid` and `in_ready` are both high at a clock edge. A trace write moves when `wr_valid` and `wr_ready` are both high. While a finished trace waits for `wr_ready`, its fields stay frozen. `in_ready` stays low until the waiting trace is taken, or is being taken in that same cycle. `in_ready` is also low in any cycle where `flush` is high.

Top module: `trace_fill_unit`

## Requirements
- R1: A trace holds at most 16 instructions. Accepting the 16th instruction always closes the trace. If that instruction is not a conditional branch, ends-in-branch is 0 and the target is 0. Every written trace carries a fall-through equal to the PC of its last instruction plus 4.
- R2: A conditional branch (class 1) closes the trace and sets ends-in-branch to 1 in two cases: two conditional branches are already embedded in the trace, or the branch is the 16th instruction. The written target is then that branch's target. Such an ending branch is not counted in the mask or the flags.
- R3: An indirect branch (class 2), a return (class 3) or a system call (class 4) closes the trace in any slot. The write then has ends-in-branch 0 and target 0.
- R4: Every conditional branch that does not close the trace is embedded. The k-th embedded branch (k = 0, 1) sets mask bit 1-k. Flag bit 1-k holds its direction, 1 for taken. The mask therefore reads 00, 10 or 11.
- R5: The written tag is bits 31:10 of the trace's first PC, and the index is bits 9:2 of that PC.
- R6: Slot k (bits 32k+31:32k of the instruction field) holds the k-th instruction of the trace. Unused slots and unused flag bits are written as zero.
- R7: After a trace closes, the next accepted instruction starts a new trace in slot 0.
- R8: While `flush` is high, `in_ready` is low and the partly built trace is dropped without any write. The next accepted instruction starts a new trace.
- R9: While `wr_valid` is high and `wr_ready` is low, every write field stays unchanged, and `in_ready` is low.
- R10: Class codes 0, 5, 6 and 7 are ordinary instructions. They end a trace only through the 16-instruction limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Drop the partly built trace |
| in_valid | input | 1 | Retired instruction present |
| in_ready | output | 1 | Unit can take an instruction |
| in_instr | input | 32 | Instruction word |
| in_pc | input | 32 | Instruction PC |
| in_class | input | 3 | 0 other, 1 conditional, 2 indirect, 3 return, 4 system call |
| in_taken | input | 1 | Resolved direction of a conditional branch |
| in_target | input | 32 | Branch target |
| wr_valid | output | 1 | Trace write present |
| wr_ready | input | 1 | Trace cache takes the write |
| wr_tag | output | 22 | Tag from the start PC |
| wr_index | output | 8 | Set index from the start PC |
| wr_instrs | output | 512 | Sixteen packed instruction slots, slot 0 lowest |
| wr_flags | output | 2 | Directions of embedded branches |
| wr_mask | output | 2 | Embedded-branch mask, leading ones |
| wr_ends_br | output | 1 | Trace ends in a conditional branch |
| wr_fallthru | output | 32 | Next PC when there is no ending branch or it is not taken |
| wr_target | output | 32 | Next PC when the ending branch is taken |

## Verification
The assertions check several things on every cycle:
- a sixteenth instruction or a multi-target transfer is always followed by a write;
- the written mask always has the leading-ones shape, and no flag is set outside it;
- a stalled write holds steady;
- a flush empties the line buffer;
- the embedded-branch count stays bounded.

Only the bench's scenarios can show that the right data comes out. That covers the exact slot contents and their zero padding, the tag and index split, and which conditional branch becomes the ending one. It also covers the next-address values, the absence of any write after a flush, and in-order delivery under random back-pressure.

// File: rtl/tfu_pkg.sv
package tfu_pkg;
  typedef enum logic [2:0] {
    CLS_OTHER = 3'd0,
    CLS_COND  = 3'd1,
    CLS_IND   = 3'd2,
    CLS_RET   = 3'd3,
    CLS_SYS   = 3'd4
  } cls_e;

  function automatic logic cls_is_multi(input logic [2:0] c);
    return (c == CLS_IND) || (c == CLS_RET) || (c == CLS_SYS);
  endfunction

  function automatic logic cls_is_cond(input logic [2:0] c);
    return c == CLS_COND;
  endfunction
endpackage

// File: rtl/tfu_stop_decide.sv
module tfu_stop_decide
  import tfu_pkg::*;
#(
  parameter int MAX_INSTR  = 16,
  parameter int MAX_BLOCKS = 3,
  localparam int CNT_W = $clog2(MAX_INSTR),
  localparam int BR_W  = $clog2(MAX_BLOCKS)
) (
  input  logic [2:0]      cls,
  input  logic [CNT_W-1:0] icnt,
  input  logic [BR_W-1:0]  bcnt,
  output logic            close,
  output logic            end_cond,
  output logic            embed
);
  logic last_slot, blocks_full, cond_br;

  always_comb begin
    cond_br     = cls_is_cond(cls);
    last_slot   = (icnt == CNT_W'(MAX_INSTR - 1));
    blocks_full = (bcnt == BR_W'(MAX_BLOCKS - 1));
    end_cond    = cond_br && (blocks_full || last_slot);
    embed       = cond_br && !end_cond;
    close       = cls_is_multi(cls) || last_slot || end_cond;
  end
endmodule

// File: rtl/tfu_line_buf.sv
module tfu_line_buf #(
  parameter int INSTR_W    = 32,
  parameter int ADDR_W     = 32,
  parameter int MAX_INSTR  = 16,
  parameter int MAX_BLOCKS = 3,
  localparam int CNT_W = $clog2(MAX_INSTR),
  localparam int BR_W  = $clog2(MAX_BLOCKS),
  localparam int MB    = MAX_BLOCKS - 1,
  localparam int PC_HI = ADDR_W - 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clear,
  input  logic                         push,
  input  logic                         close,
  input  logic                         embed,
  input  logic                         taken,
  input  logic [INSTR_W-1:0]           instr,
  input  logic [PC_HI-1:0]             pc_hi,
  output logic [CNT_W-1:0]             icnt,
  output logic [BR_W-1:0]              bcnt,
  output logic [MAX_INSTR*INSTR_W-1:0] cur_slots,
  output logic [MB-1:0]                cur_flags,
  output logic [MB-1:0]                cur_mask,
  output logic [PC_HI-1:0]             cur_start
);
  logic [CNT_W-1:0] icnt_q;
  logic [BR_W-1:0]  bcnt_q;
  logic [MB-1:0]    flags_q, mask_q, flags_n, mask_n;
  logic [PC_HI-1:0] start_q;
  logic             restart;

  assign restart = clear || (push && close);

  for (genvar i = 0; i < MAX_INSTR; i++) begin : g_slot
    logic [INSTR_W-1:0] slot_q, slot_n;
    assign slot_n = (push && icnt_q == CNT_W'(i)) ? instr : slot_q;
    assign cur_slots[i*INSTR_W +: INSTR_W] = slot_n;
    always_ff @(posedge clk) begin
      if (!rst_n || restart) slot_q <= '0;
      else                   slot_q <= slot_n;
    end
  end

  always_comb begin
    flags_n = flags_q;
    mask_n  = mask_q;
    for (int k = 0; k < MB; k++) begin
      if (push && embed && (int'(bcnt_q) == MB - 1 - k)) begin
        flags_n[k] = taken;
        mask_n[k]  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      icnt_q  <= '0;
      bcnt_q  <= '0;
      flags_q <= '0;
      mask_q  <= '0;
      start_q <= '0;
    end else if (push) begin
      icnt_q  <= icnt_q + 1'b1;
      bcnt_q  <= bcnt_q + BR_W'(embed);
      flags_q <= flags_n;
      mask_q  <= mask_n;
      if (icnt_q == '0) start_q <= pc_hi;
    end
  end

  assign icnt      = icnt_q;
  assign bcnt      = bcnt_q;
  assign cur_flags = flags_n;
  assign cur_mask  = mask_n;
  assign cur_start = (icnt_q == '0) ? pc_hi : start_q;

  a_r8_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (icnt_q == '0) && (bcnt_q == '0) && (mask_q == '0));
  a_r2_branch_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(bcnt_q) <= MB);
endmodule

// File: rtl/tfu_wr_hold.sv
module tfu_wr_hold #(
  parameter int TAG_W  = 22,
  parameter int IDX_W  = 8,
  parameter int LINE_W = 512,
  parameter int MB     = 2,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [TAG_W-1:0]  d_tag,
  input  logic [IDX_W-1:0]  d_index,
  input  logic [LINE_W-1:0] d_instrs,
  input  logic [MB-1:0]     d_flags,
  input  logic [MB-1:0]     d_mask,
  input  logic              d_ends_br,
  input  logic [ADDR_W-1:0] d_fallthru,
  input  logic [ADDR_W-1:0] d_target,
  output logic              free,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [TAG_W-1:0]  wr_tag,
  output logic [IDX_W-1:0]  wr_index,
  output logic [LINE_W-1:0] wr_instrs,
  output logic [MB-1:0]     wr_flags,
  output logic [MB-1:0]     wr_mask,
  output logic              wr_ends_br,
  output logic [ADDR_W-1:0] wr_fallthru,
  output logic [ADDR_W-1:0] wr_target
);
  assign free = !wr_valid || wr_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_valid    <= 1'b0;
      wr_tag      <= '0;
      wr_index    <= '0;
      wr_instrs   <= '0;
      wr_flags    <= '0;
      wr_mask     <= '0;
      wr_ends_br  <= 1'b0;
      wr_fallthru <= '0;
      wr_target   <= '0;
    end else if (load) begin
      wr_valid    <= 1'b1;
      wr_tag      <= d_tag;
      wr_index    <= d_index;
      wr_instrs   <= d_instrs;
      wr_flags    <= d_flags;
      wr_mask     <= d_mask;
      wr_ends_br  <= d_ends_br;
      wr_fallthru <= d_fallthru;
      wr_target   <= d_target;
    end else if (wr_ready) begin
      wr_valid <= 1'b0;
    end
  end

  a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_tag) && $stable(wr_index)
      && $stable(wr_instrs) && $stable(wr_flags) && $stable(wr_mask)
      && $stable(wr_ends_br) && $stable(wr_fallthru) && $stable(wr_target));
  a_r9_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> free);
endmodule

// File: rtl/trace_fill_unit.sv
module trace_fill_unit
  import tfu_pkg::*;
#(
  parameter int INSTR_W    = 32,
  parameter int ADDR_W     = 32,
  parameter int IDX_W      = 8,
  parameter int MAX_INSTR  = 16,
  parameter int MAX_BLOCKS = 3,
  localparam int TAG_W  = ADDR_W - IDX_W - 2,
  localparam int LINE_W = MAX_INSTR * INSTR_W,
  localparam int MB     = MAX_BLOCKS - 1,
  localparam int CNT_W  = $clog2(MAX_INSTR),
  localparam int BR_W   = $clog2(MAX_BLOCKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [INSTR_W-1:0] in_instr,
  input  logic [ADDR_W-1:0] in_pc,
  input  logic [2:0]        in_class,
  input  logic              in_taken,
  input  logic [ADDR_W-1:0] in_target,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [TAG_W-1:0]  wr_tag,
  output logic [IDX_W-1:0]  wr_index,
  output logic [LINE_W-1:0] wr_instrs,
  output logic [MB-1:0]     wr_flags,
  output logic [MB-1:0]     wr_mask,
  output logic              wr_ends_br,
  output logic [ADDR_W-1:0] wr_fallthru,
  output logic [ADDR_W-1:0] wr_target
);
  logic             push, close, end_cond, embed, free;
  logic [CNT_W-1:0] icnt;
  logic [BR_W-1:0]  bcnt;
  logic [LINE_W-1:0] cur_slots;
  logic [MB-1:0]    cur_flags, cur_mask;
  logic [ADDR_W-3:0] cur_start;

  assign in_ready = free && !flush;
  assign push     = in_valid && in_ready;

  tfu_stop_decide #(.MAX_INSTR(MAX_INSTR), .MAX_BLOCKS(MAX_BLOCKS)) i_decide (
    .cls(in_class), .icnt(icnt), .bcnt(bcnt),
    .close(close), .end_cond(end_cond), .embed(embed)
  );

  tfu_line_buf #(.INSTR_W(INSTR_W), .ADDR_W(ADDR_W), .MAX_INSTR(MAX_INSTR),
                 .MAX_BLOCKS(MAX_BLOCKS)) i_line (
    .clk(clk), .rst_n(rst_n), .clear(flush), .push(push), .close(close),
    .embed(embed), .taken(in_taken), .instr(in_instr),
    .pc_hi(in_pc[ADDR_W-1:2]), .icnt(icnt), .bcnt(bcnt),
    .cur_slots(cur_slots), .cur_flags(cur_flags), .cur_mask(cur_mask),
    .cur_start(cur_start)
  );

  tfu_wr_hold #(.TAG_W(TAG_W), .IDX_W(IDX_W), .LINE_W(LINE_W), .MB(MB),
                .ADDR_W(ADDR_W)) i_hold (
    .clk(clk), .rst_n(rst_n), .load(push && close),
    .d_tag(cur_start[ADDR_W-3 -: TAG_W]), .d_index(cur_start[IDX_W-1:0]),
    .d_instrs(cur_slots), .d_flags(cur_flags), .d_mask(cur_mask),
    .d_ends_br(end_cond), .d_fallthru(in_pc + ADDR_W'(4)),
    .d_target(end_cond ? in_target : '0),
    .free(free), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_tag(wr_tag), .wr_index(wr_index), .wr_instrs(wr_instrs),
    .wr_flags(wr_flags), .wr_mask(wr_mask), .wr_ends_br(wr_ends_br),
    .wr_fallthru(wr_fallthru), .wr_target(wr_target)
  );

  a_r1_full_closes: assert property (@(posedge clk) disable iff (!rst_n)
    push && (icnt == CNT_W'(MAX_INSTR - 1)) |=> wr_valid);
  a_r3_multi_stop: assert property (@(posedge clk) disable iff (!rst_n)
    push && cls_is_multi(in_class) |=> wr_valid && !wr_ends_br && (wr_target == '0));
  a_r4_mask_shape: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> wr_mask == ~({MB{1'b1}} >> $countones(wr_mask)));
  a_r6_flags_in_mask: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_flags & ~wr_mask) == '0);
endmodule

// File: tb/test_trace_fill_unit.sv
`timescale 1ns/1ps
module test_trace_fill_unit;
  logic clk = 0, rst_n = 0, flush = 0, in_valid = 0, in_taken = 0, wr_ready = 1;
  logic in_ready, wr_valid, wr_ends_br;
  logic [31:0] in_instr = 0, in_pc = 0, in_target = 0, wr_fallthru, wr_target;
  logic [2:0] in_class = 0;
  logic [21:0] wr_tag;
  logic [7:0] wr_index;
  logic [511:0] wr_instrs;
  logic [1:0] wr_flags, wr_mask;

  always #2 clk = ~clk;

  trace_fill_unit i_trace_fill_unit (.*);

  typedef struct {
    logic [21:0] tag; logic [7:0] idx; logic [511:0] slots;
    logic [1:0] flags, mask; logic eb; logic [31:0] ft, tg;
  } exp_t;
  exp_t exp_q[$];

  int total = 0, bad = 0, rdy_mode = 0, wrote = 0;
  bit done = 0;

  int m_cnt = 0, m_bcnt = 0;
  logic [511:0] m_slots = '0;
  logic [1:0] m_flags = 0, m_mask = 0;
  logic [31:0] m_start = 0;

  task automatic chk(input bit ok, input string req, input logic [511:0] act, input logic [511:0] exp);
    total++;
    if (!ok) begin bad++; $display("FAIL %s act=%0h exp=%0h", req, act, exp); end
  endtask

  task automatic model_reset();
    m_cnt = 0; m_bcnt = 0; m_slots = '0; m_flags = 0; m_mask = 0;
  endtask

  task automatic feed(input logic [31:0] pc, input logic [31:0] ins, input logic [2:0] cls,
                      input bit tk, input logic [31:0] tgt);
    bit isc, multi, last, endc;
    exp_t e;
    @(negedge clk);
    in_valid = 1; in_pc = pc; in_instr = ins; in_class = cls; in_taken = tk; in_target = tgt;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    #1 in_valid = 0;
    if (m_cnt == 0) m_start = pc;
    m_slots[m_cnt*32 +: 32] = ins;
    isc = (cls == 3'd1);
    multi = (cls == 3'd2) || (cls == 3'd3) || (cls == 3'd4);
    last = (m_cnt == 15);
    endc = isc && (m_bcnt == 2 || last);
    if (isc && !endc) begin m_mask[1-m_bcnt] = 1'b1; m_flags[1-m_bcnt] = tk; m_bcnt++; end
    m_cnt++;
    if (multi || last || endc) begin
      e.tag = m_start[31:10]; e.idx = m_start[9:2]; e.slots = m_slots;
      e.flags = m_flags; e.mask = m_mask; e.eb = endc; e.ft = pc + 32'd4;
      e.tg = endc ? tgt : 32'd0;
      exp_q.push_back(e);
      model_reset();
    end
  endtask

  logic [15:0] lfsr = 16'hACE1;
  always @(negedge clk) begin
    exp_t e;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    wr_ready = (rdy_mode == 0) ? 1'b1 : (rdy_mode == 1) ? 1'b0 : lfsr[0];
    if (rst_n && wr_valid && wr_ready) begin
      wrote++;
      if (exp_q.size() == 0) chk(0, "R8 unexpected write", {490'd0, wr_tag}, 0);
      else begin
        e = exp_q.pop_front();
        chk(wr_tag == e.tag && wr_index == e.idx, "R5 tag/index", {wr_tag, wr_index}, {e.tag, e.idx});
        chk(wr_instrs == e.slots, "R6 R7 slots", wr_instrs, e.slots);
        chk(wr_mask == e.mask && wr_flags == e.flags, "R4 mask/flags", {wr_mask, wr_flags}, {e.mask, e.flags});
        chk(wr_ends_br == e.eb, "R2 R3 R10 ends_br", wr_ends_br, e.eb);
        chk(wr_fallthru == e.ft, "R1 fallthru", wr_fallthru, e.ft);
        chk(wr_target == e.tg, "R2 R3 target", wr_target, e.tg);
      end
    end
  end

  task automatic drain();
    int t = 0;
    while ((exp_q.size() != 0 || wr_valid) && t < 2000) begin @(negedge clk); t++; end
    #1 chk(exp_q.size() == 0, "R9 drained", exp_q.size(), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++; $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] pc;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    chk(!wr_valid, "R9 reset wr_valid", wr_valid, 0);
    rst_n = 1;
    @(negedge clk); #1;
    chk(in_ready, "R9 reset in_ready", in_ready, 1);

    // R1: sixteen ordinary instructions
    for (int i = 0; i < 16; i++) feed(32'h0040_1000 + 4*i, 32'h1000 + i, 3'd0, 0, 0);
    drain();
    // R2 R4: three blocks, third branch ends the trace
    feed(32'h0000_2400, 32'hA0, 0, 0, 0);
    feed(32'h0000_2404, 32'hA1, 1, 1, 32'h3000);
    feed(32'h0000_3000, 32'hA2, 0, 0, 0);
    feed(32'h0000_3004, 32'hA3, 1, 0, 32'h5000);
    feed(32'h0000_3008, 32'hA4, 1, 1, 32'h6000);
    // R3: return after one embedded branch; indirect alone; syscall
    feed(32'h0000_6000, 32'hB0, 1, 0, 32'h7000);
    feed(32'h0000_6004, 32'hB1, 3, 0, 32'h1234);
    feed(32'h0000_8000, 32'hB2, 2, 0, 32'h1234);
    feed(32'h0000_9000, 32'hB3, 0, 0, 0);
    feed(32'h0000_9004, 32'hB4, 4, 0, 0);
    drain();
    // R10: codes 5..7 are ordinary
    for (int i = 0; i < 16; i++) feed(32'hFFC0_0000 + 4*i, 32'hC00 + i, 3'(5 + i % 3), 0, 0);
    // R2: conditional branch as 16th instruction
    for (int i = 0; i < 15; i++) feed(32'h1234_5600 + 4*i, 32'hD00 + i, 0, 0, 0);
    feed(32'h1234_563C, 32'hD0F, 1, 1, 32'h4444);
    drain();
    // R8: flush drops partial trace
    feed(32'h0000_A000, 32'hE0, 0, 0, 0);
    feed(32'h0000_A004, 32'hE1, 1, 1, 32'hB000);
    @(negedge clk); flush = 1; #1;
    chk(!in_ready, "R8 in_ready low in flush", in_ready, 0);
    @(negedge clk); flush = 0;
    model_reset();
    feed(32'h0000_C000, 32'hE2, 3, 0, 0);
    drain();
    chk(wrote == 8, "R8 write count", wrote, 8);
    // R9: back-pressure
    rdy_mode = 1;
    feed(32'h0000_D000, 32'hF0, 2, 0, 0);
    repeat (3) @(negedge clk);
    #1 chk(wr_valid && !in_ready, "R9 stall holds", {wr_valid, in_ready}, 2'b10);
    rdy_mode = 0;
    drain();
    // R7 R9: random stream under random back-pressure
    rdy_mode = 2;
    pc = 32'h0010_0000;
    for (int i = 0; i < 300; i++) begin
      logic [2:0] c; bit tk; logic [31:0] tg;
      int r = $urandom_range(0, 19);
      c = (r < 12) ? 3'd0 : (r < 17) ? 3'd1 : 3'(r - 15);
      tk = 1'($urandom_range(0, 1));
      tg = {$urandom_range(0, 32'hFFFF), 2'b00} + 32'h0020_0000;
      feed(pc, $urandom, c, tk, tg);
      pc = (c == 3'd1 && tk) ? tg : (c >= 3'd2 ? tg : pc + 4);
    end
    rdy_mode = 0;
    drain();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule